// File: doc/BRIEF.md
# Calendar Day and Month Counter

This block keeps the calendar date (day of month and month of year) as two-digit packed BCD values. A one-cycle advance pulse, raised by the time-of-day counter when it passes midnight, moves the date forward by one day. When the day passes the last day of the current month, it returns to 01 and the month moves on. After month 12 the month returns to 01.

The month value is decoded into a 2-bit length class, and that class is fed back to set the day counter's terminal count. The three classes are a 28-day February, 30-day months and 31-day months. Only common years are modelled, so February always ends on day 28.

Two correction pulses let an operator set the date by hand. Each one steps only its own field and never carries into the other field. If a month correction lands on a month shorter than the current day, the day is pulled back to that month's last day.

Top module: `cal_date_counter`

## Requirements
- R1: While reset is asserted (active low), the outputs show day 0x01, month 0x01 and length code 2'b10.
- R2: The length code is 2'b00 for month 0x02, 2'b01 for months 0x04, 0x06, 0x09 and 0x11, and 2'b10 for every other month.
- R3: An advance pulse on a day below the month's last day adds one to the day in BCD (0x09 becomes 0x10, 0x19 becomes 0x20), and the month does not change.
- R4: In February, an advance pulse on day 0x28 sets the day to 0x01 and the month to 0x03.
- R5: In a 30-day month, an advance pulse on day 0x30 sets the day to 0x01 and advances the month by one.
- R6: In a 31-day month, an advance pulse on day 0x31 sets the day to 0x01 and advances the month by one.
- R7: An advance pulse on day 0x31 of month 0x12 sets the date to day 0x01 of month 0x01.
- R8: A day correction pulse adds one to the day and wraps from the month's last day to 0x01. The month never changes.
- R9: A month correction pulse adds one to the month and wraps from 0x12 to 0x01. The day does not change when it is valid in the new month.
- R10: If a month correction leaves the day beyond the new month's last day, the day becomes that last day.
- R11: When the advance pulse is high, both corrections are ignored in that cycle. When a month correction and a day correction are high together, only the month correction takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dayAdvance | input | 1 | One-cycle pulse that moves the date forward by one day |
| dayCorrect | input | 1 | One-cycle pulse that steps the day field only |
| monthCorrect | input | 1 | One-cycle pulse that steps the month field only |
| dayBcd | output | 8 | Day of month, packed BCD, 0x01 to 0x31 |
| monthBcd | output | 8 | Month, packed BCD, 0x01 to 0x12 |
| lenCode | output | 2 | Length class of the current month |

## Verification
The day and month registers take a new value on the rising edge that samples a pulse. The length code is decoded combinationally from the month register, so it is valid in that same cycle. The bench drives each pulse on a falling edge, removes it on the next falling edge, and samples all three outputs at that second falling edge, which is exactly one rising edge after the pulse. A bench model applies the same priority and wrap rules to predict every value. The scenarios walk a whole common year day by day, step every month by correction, force clamps, and raise several pulses together.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [1:0] {
    LEN_FEB   = 2'b00,
    LEN_SHORT = 2'b01,
    LEN_LONG  = 2'b10
  } lenCode_t;

  typedef struct packed {
    logic dayInc;
    logic dayRestart;
    logic monthInc;
    logic dayClamp;
  } calStrobe_t;

  function automatic logic [7:0] toBcd(input int v);
    logic [7:0] r;
    r[7:4] = 4'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) begin
      r[3:0] = 4'd0;
      r[7:4] = v[7:4] + 4'd1;
    end else begin
      r[3:0] = v[3:0] + 4'd1;
      r[7:4] = v[7:4];
    end
    return r;
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dayAdvance,
  input  logic       dayCorrect,
  input  logic       monthCorrect,
  input  logic       atLastDay,
  output calStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (dayAdvance) begin
      strobe.dayInc     = !atLastDay;
      strobe.dayRestart = atLastDay;
      strobe.monthInc   = atLastDay;
    end else if (monthCorrect) begin
      strobe.monthInc = 1'b1;
      strobe.dayClamp = 1'b1;
    end else if (dayCorrect) begin
      strobe.dayInc     = !atLastDay;
      strobe.dayRestart = atLastDay;
    end
  end

  // R11: never two day actions at once
  assert_one_day_action_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.dayInc, strobe.dayRestart, strobe.dayClamp}));

  // R8: a correction of the day alone never moves the month
  assert_day_fix_no_carry_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dayCorrect && !dayAdvance && !monthCorrect) |-> !strobe.monthInc);

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int FebDays   = 28,
  parameter int ShortDays = 30,
  parameter int LongDays  = 31,
  parameter int YearMonths = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strobe,
  output logic       atLastDay,
  output logic [7:0] dayBcd,
  output logic [7:0] monthBcd,
  output logic [1:0] lenCode
);

  localparam logic [7:0] FebLast   = toBcd(FebDays);
  localparam logic [7:0] ShortLast = toBcd(ShortDays);
  localparam logic [7:0] LongLast  = toBcd(LongDays);
  localparam logic [7:0] LastMonth = toBcd(YearMonths);
  localparam logic [7:0] FirstVal  = 8'h01;

  logic [7:0] dayQ, monthQ, monthNext, lastDay, nextLastDay;
  lenCode_t   curCode, nextCode;

  function automatic lenCode_t classify(input logic [7:0] m);
    case (m)
      8'h02:                      return LEN_FEB;
      8'h04, 8'h06, 8'h09, 8'h11: return LEN_SHORT;
      default:                    return LEN_LONG;
    endcase
  endfunction

  function automatic logic [7:0] lastOf(input lenCode_t c);
    case (c)
      LEN_FEB:   return FebLast;
      LEN_SHORT: return ShortLast;
      default:   return LongLast;
    endcase
  endfunction

  always_comb begin
    curCode     = classify(monthQ);
    lastDay     = lastOf(curCode);
    monthNext   = (monthQ == LastMonth) ? FirstVal : bcdInc(monthQ);
    nextCode    = classify(monthNext);
    nextLastDay = lastOf(nextCode);
    atLastDay   = (dayQ >= lastDay);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dayQ   <= FirstVal;
      monthQ <= FirstVal;
    end else begin
      if (strobe.dayRestart)
        dayQ <= FirstVal;
      else if (strobe.dayInc)
        dayQ <= bcdInc(dayQ);
      else if (strobe.dayClamp && dayQ > nextLastDay)
        dayQ <= nextLastDay;
      if (strobe.monthInc)
        monthQ <= monthNext;
    end
  end

  assign dayBcd   = dayQ;
  assign monthBcd = monthQ;
  assign lenCode  = curCode;

  // R10: the day never exceeds the length of the current month
  assert_day_in_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    dayQ >= FirstVal && dayQ <= lastOf(classify(monthQ)));

  // R9: the month stays in 1..12
  assert_month_in_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    monthQ >= FirstVal && monthQ <= LastMonth);

  // R2: the reserved class code never appears
  assert_code_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    lenCode != 2'b11);

  // R5: restarting the day always comes with a month step on advance
  assert_wrap_to_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dayRestart && strobe.monthInc) |=> (dayQ == FirstVal && monthQ != $past(monthQ)));

endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter
  import cal_pkg::*;
#(
  parameter int FebDays    = 28,
  parameter int ShortDays  = 30,
  parameter int LongDays   = 31,
  parameter int YearMonths = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dayAdvance,
  input  logic       dayCorrect,
  input  logic       monthCorrect,
  output logic [7:0] dayBcd,
  output logic [7:0] monthBcd,
  output logic [1:0] lenCode
);

  calStrobe_t strobe;
  logic       atLastDay;

  cal_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .dayAdvance   (dayAdvance),
    .dayCorrect   (dayCorrect),
    .monthCorrect (monthCorrect),
    .atLastDay    (atLastDay),
    .strobe       (strobe)
  );

  cal_datapath #(
    .FebDays    (FebDays),
    .ShortDays  (ShortDays),
    .LongDays   (LongDays),
    .YearMonths (YearMonths)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .atLastDay (atLastDay),
    .dayBcd    (dayBcd),
    .monthBcd  (monthBcd),
    .lenCode   (lenCode)
  );

endmodule

// File: tb/cal_date_counter_bench.sv
module cal_date_counter_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dayAdvance = 1'b0, dayCorrect = 1'b0, monthCorrect = 1'b0;
  logic [7:0] dayBcd, monthBcd;
  logic [1:0] lenCode;

  int checks = 0;
  int errors = 0;
  int expDay = 1;
  int expMonth = 1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cal_date_counter u_cal_date_counter (
    .clk(clk), .rstN(rstN), .dayAdvance(dayAdvance), .dayCorrect(dayCorrect),
    .monthCorrect(monthCorrect), .dayBcd(dayBcd), .monthBcd(monthBcd), .lenCode(lenCode)
  );

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int monthLen(input int m);
    if (m == 2) return 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [1:0] codeOf(input int m);
    if (m == 2) return 2'b00;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 2'b01;
    return 2'b10;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (date %0d/%0d)", req, act, exp, expDay, expMonth);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, dayBcd, bcd(expDay));
    check(req, monthBcd, bcd(expMonth));
    check({req, "/R2"}, {6'd0, lenCode}, {6'd0, codeOf(expMonth)});
  endtask

  // one pulse pattern, model update, check one rising edge later
  task automatic apply(input bit a, input bit d, input bit m, input string req);
    @(negedge clk);
    dayAdvance = a; dayCorrect = d; monthCorrect = m;
    if (a) begin
      if (expDay == monthLen(expMonth)) begin
        expDay = 1;
        expMonth = (expMonth == 12) ? 1 : expMonth + 1;
      end else expDay++;
    end else if (m) begin
      expMonth = (expMonth == 12) ? 1 : expMonth + 1;
      if (expDay > monthLen(expMonth)) expDay = monthLen(expMonth);
    end else if (d) begin
      expDay = (expDay == monthLen(expMonth)) ? 1 : expDay + 1;
    end
    @(negedge clk);
    dayAdvance = 1'b0; dayCorrect = 1'b0; monthCorrect = 1'b0;
    checkAll(req);
  endtask

  task automatic testReset();
    checkAll("R1");
  endtask

  task automatic testMonthCorrectCycle();
    for (int i = 0; i < 12; i++) apply(0, 0, 1, "R9");
  endtask

  task automatic testYearWalk();
    for (int i = 0; i < 365; i++) begin
      if (expDay == 28 && expMonth == 2) apply(1, 0, 0, "R4");
      else if (expDay == 31 && expMonth == 12) apply(1, 0, 0, "R7");
      else if (expDay == 30 && monthLen(expMonth) == 30) apply(1, 0, 0, "R5");
      else if (expDay == 31) apply(1, 0, 0, "R6");
      else apply(1, 0, 0, "R3");
    end
    check("R7", {7'd0, (expDay == 1 && expMonth == 1)}, 8'd1);
  endtask

  task automatic testDayCorrect();
    for (int i = 0; i < 32; i++) apply(0, 1, 0, "R8");
  endtask

  task automatic testClamp();
    while (expDay != 31) apply(0, 1, 0, "R8");
    apply(0, 0, 1, "R10");
    check("R10", dayBcd, 8'h28);
    apply(0, 0, 1, "R9");
    while (expDay != 31) apply(0, 1, 0, "R8");
    apply(0, 0, 1, "R10");
    check("R10", dayBcd, 8'h30);
  endtask

  task automatic testPriority();
    apply(1, 1, 1, "R11");
    apply(0, 1, 1, "R11");
    apply(1, 1, 0, "R11");
    apply(1, 0, 1, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");
    testMonthCorrectCycle();
    testYearWalk();
    testDayCorrect();
    testClamp();
    testPriority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule